// File: doc/BRIEF.md
# Mode Register Load Sequencer

This block programs the two mode registers of a mobile DDR memory. It runs at the end of power-up and again whenever the operating mode has to change. A one-cycle start request captures both register values and the order setting. The block then waits until every bank is idle and no burst is running, and issues a LOAD MODE REGISTER command for the first register. After that it fills a fixed gap with NOP commands, checks the bank and burst status again, loads the second register and fills a second gap.

When the second gap ends, the block raises a ready level. Ready stays high until one of three things happens: a new start request, a deep power-down entry or a power-loss indication. Either of the last two also aborts a sequence that is in progress. While the block has no command to issue, it deselects the memory.

Top module: `modereg_loader`

## Requirements
- R1: During and after reset the command outputs show DESELECT (chip select, row, column and write strobes all 1), the bank and address outputs are 0, and ready is 0.
- R2: A start request sampled while the block is not sequencing produces one DESELECT cycle. Then comes a LOAD MODE REGISTER command (all four strobes 0) for the first register. When the order input is 0, the first register is the standard register, with bank 00 and the address carrying the standard value.
- R3: Each load command is followed by exactly GAP_CYC cycles of NOP (chip select 0, the other three strobes 1), with bank and address 0.
- R4: The extended register is loaded with bank 10 (bit 1 set, bit 0 clear) and the extended value. An order input of 1, sampled with the start request, loads the extended register first and the standard register second.
- R5: A load command appears only in the cycle after a clock edge at which banks-idle was 1 and burst-active was 0. Otherwise the block keeps issuing DESELECT until both conditions hold.
- R6: Ready rises in the cycle after the last NOP of the second gap and stays high, with DESELECT on the bus, until a start, power-down or power-loss input.
- R7: A start request that arrives while a sequence is running has no effect on the command stream or on ready.
- R8: Deep power-down entry or power loss drops ready in the next cycle and aborts any running sequence. The bus then shows DESELECT.
- R9: The register values are captured with the start request. Later changes on the value inputs do not alter the loads that follow.
- R10: A start request while ready is high drops ready in the next cycle and begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | One-cycle request to program both registers |
| ext_first | input | 1 | Order select: 1 loads the extended register first |
| std_val | input | ADDR_W | Value for the standard mode register |
| ext_val | input | ADDR_W | Value for the extended mode register |
| banks_idle | input | 1 | All banks are idle |
| burst_busy | input | 1 | A read or write burst is in progress |
| dpd_enter | input | 1 | Memory enters deep power-down |
| pwr_lost | input | 1 | Memory supply was lost |
| cs_n | output | 1 | Chip select strobe, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| ba | output | BA_W | Bank address, selects the target register |
| addr | output | ADDR_W | Address bus carrying the register value |
| ready | output | 1 | Both registers hold valid programmed values |

## Verification
The hardest case to reach is the hold-off before the second load. By then the first load and its whole NOP gap have finished, so the bench has to drop banks-idle, or raise burst-active, at exactly the right point in the sequence. The stimulus drives these status lines high before the second hold cycle and keeps them there for several cycles. It also drops them again on their own before the first load. The reference model releases the pending load only when both conditions hold on the same edge, so the bench checks every DESELECT cycle of the hold-off and the one cycle where the load finally appears.

// File: rtl/mrl_pkg.sv
package mrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_HOLD_A = 3'd1,
      ST_LOAD_A = 3'd2,
      ST_GAP_A  = 3'd3,
      ST_HOLD_B = 3'd4,
      ST_LOAD_B = 3'd5,
      ST_GAP_B  = 3'd6
   } mrl_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } mrl_cmd_t;

   localparam mrl_cmd_t CMD_DESEL = 4'b1111;
   localparam mrl_cmd_t CMD_NOP   = 4'b0111;
   localparam mrl_cmd_t CMD_LMR   = 4'b0000;

   // bank bit that steers a load to the extended register
   localparam int EXT_BA_BIT = 1;

   function automatic logic is_gap(input mrl_state_e s);
      return (s == ST_GAP_A) || (s == ST_GAP_B);
   endfunction

   function automatic logic is_load(input mrl_state_e s);
      return (s == ST_LOAD_A) || (s == ST_LOAD_B);
   endfunction

endpackage

// File: rtl/mrl_gap_timer.sv
module mrl_gap_timer #(
   parameter int GAP_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);

   localparam int CNT_W = (GAP_CYC > 2) ? $clog2(GAP_CYC) : 1;
   localparam logic [CNT_W-1:0] START_VAL = CNT_W'(GAP_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= START_VAL;
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/mrl_ctrl.sv
module mrl_ctrl
   import mrl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_req,
   input  logic       safe,
   input  logic       abort,
   input  logic       gap_done,
   output mrl_state_e state,
   output logic       gap_load,
   output logic       gap_run,
   output logic       cap_en,
   output logic       valid
);

   mrl_state_e st_q, st_d;

   always_comb begin
      st_d     = st_q;
      gap_load = 1'b0;
      cap_en   = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (start_req) begin
               st_d   = ST_HOLD_A;
               cap_en = 1'b1;
            end
         end
         ST_HOLD_A: if (safe) st_d = ST_LOAD_A;
         ST_LOAD_A: begin
            st_d     = ST_GAP_A;
            gap_load = 1'b1;
         end
         ST_GAP_A:  if (gap_done) st_d = ST_HOLD_B;
         ST_HOLD_B: if (safe) st_d = ST_LOAD_B;
         ST_LOAD_B: begin
            st_d     = ST_GAP_B;
            gap_load = 1'b1;
         end
         ST_GAP_B:  if (gap_done) st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
      if (abort) begin
         st_d     = ST_IDLE;
         gap_load = 1'b0;
         cap_en   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
      end else if (abort) begin
         valid <= 1'b0;
      end else if ((st_q == ST_IDLE) && start_req) begin
         valid <= 1'b0;
      end else if ((st_q == ST_GAP_B) && gap_done) begin
         valid <= 1'b1;
      end
   end

   assign state   = st_q;
   assign gap_run = is_gap(st_q);

endmodule

// File: rtl/mrl_cmd_drive.sv
module mrl_cmd_drive
   import mrl_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BA_W   = 2
) (
   input  mrl_state_e        state,
   input  logic              swap,
   input  logic [ADDR_W-1:0] std_q,
   input  logic [ADDR_W-1:0] ext_q,
   output mrl_cmd_t          cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [BA_W-1:0] BA_STD = '0;
   localparam logic [BA_W-1:0] BA_EXT = BA_W'(1) << EXT_BA_BIT;

   logic sel_ext;

   always_comb begin
      sel_ext = 1'b0;
      if (state == ST_LOAD_A) sel_ext = swap;
      if (state == ST_LOAD_B) sel_ext = ~swap;
   end

   always_comb begin
      cmd  = CMD_DESEL;
      ba   = '0;
      addr = '0;
      if (is_load(state)) begin
         cmd  = CMD_LMR;
         ba   = sel_ext ? BA_EXT : BA_STD;
         addr = sel_ext ? ext_q : std_q;
      end else if (is_gap(state)) begin
         cmd = CMD_NOP;
      end
   end

endmodule

// File: rtl/modereg_loader.sv
module modereg_loader
   import mrl_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int BA_W       = 2,
   parameter int GAP_CYC    = 2,
   parameter int ORDER_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic              ext_first,
   input  logic [ADDR_W-1:0] std_val,
   input  logic [ADDR_W-1:0] ext_val,
   input  logic              banks_idle,
   input  logic              burst_busy,
   input  logic              dpd_enter,
   input  logic              pwr_lost,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              ready
);

   generate
      if (GAP_CYC < 2 || GAP_CYC > 15) begin : g_bad_gap
         $error("GAP_CYC must lie in 2..15");
      end
      if (BA_W < 2) begin : g_bad_ba
         $error("BA_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be positive");
      end
      if (ORDER_MODE < 0 || ORDER_MODE > 2) begin : g_bad_order
         $error("ORDER_MODE must be 0, 1 or 2");
      end
   endgenerate

   mrl_state_e        state;
   mrl_cmd_t          cmd;
   logic              safe, abort, gap_done, gap_load, gap_run, cap_en, valid;
   logic [ADDR_W-1:0] std_q, ext_q;
   logic              swap_q;

   assign safe  = banks_idle & ~burst_busy;
   assign abort = dpd_enter | pwr_lost;

   mrl_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_req(start_req),
      .safe     (safe),
      .abort    (abort),
      .gap_done (gap_done),
      .state    (state),
      .gap_load (gap_load),
      .gap_run  (gap_run),
      .cap_en   (cap_en),
      .valid    (valid)
   );

   mrl_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (gap_load),
      .run    (gap_run),
      .expired(gap_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         std_q <= '0;
         ext_q <= '0;
      end else if (cap_en) begin
         std_q <= std_val;
         ext_q <= ext_val;
      end
   end

   generate
      if (ORDER_MODE == 0) begin : g_order_pin
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               swap_q <= 1'b0;
            end else if (cap_en) begin
               swap_q <= ext_first;
            end
         end
      end else if (ORDER_MODE == 1) begin : g_order_std
         logic unused_order;
         assign unused_order = ext_first;
         assign swap_q = 1'b0;
      end else begin : g_order_ext
         logic unused_order;
         assign unused_order = ext_first;
         assign swap_q = 1'b1;
      end
   endgenerate

   mrl_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drive (
      .state(state),
      .swap (swap_q),
      .std_q(std_q),
      .ext_q(ext_q),
      .cmd  (cmd),
      .ba   (ba),
      .addr (addr)
   );

   assign cs_n  = cmd.cs_n;
   assign ras_n = cmd.ras_n;
   assign cas_n = cmd.cas_n;
   assign we_n  = cmd.we_n;
   assign ready = valid;

endmodule

// File: rtl/mrl_checker.sv
module mrl_checker #(
   parameter int BA_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_req,
   input logic            banks_idle,
   input logic            burst_busy,
   input logic            dpd_enter,
   input logic            pwr_lost,
   input logic            cs_n,
   input logic            ras_n,
   input logic            cas_n,
   input logic            we_n,
   input logic [BA_W-1:0] ba,
   input logic            ready
);

   logic is_lmr, is_nop;
   assign is_lmr = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);
   assign is_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);

   p_lmr_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      is_lmr |-> $past(banks_idle && !burst_busy));

   p_nop_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lmr && !dpd_enter && !pwr_lost) |=> is_nop);

   p_bank_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_lmr |-> (ba[0] == 1'b0 && (ba >> 2) == '0));

   p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> cs_n);

   p_ready_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(is_nop));

   p_loss_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dpd_enter || pwr_lost) |=> !ready);

   p_restart_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && start_req) |=> !ready);

endmodule

bind modereg_loader mrl_checker #(.BA_W(BA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_req (start_req),
   .banks_idle(banks_idle),
   .burst_busy(burst_busy),
   .dpd_enter (dpd_enter),
   .pwr_lost  (pwr_lost),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba        (ba),
   .ready     (ready)
);

// File: tb/modereg_loader_test.sv
module modereg_loader_test;
   localparam int AW  = 13;
   localparam int BW  = 2;
   localparam int GAP = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0, start_req = 1'b0, ext_first = 1'b0;
   logic banks_idle = 1'b1, burst_busy = 1'b0, dpd_enter = 1'b0, pwr_lost = 1'b0;
   logic [AW-1:0] std_val = '0, ext_val = '0;
   logic cs_n, ras_n, cas_n, we_n, ready;
   logic [BW-1:0] ba;
   logic [AW-1:0] addr;

   modereg_loader #(.ADDR_W(AW), .BA_W(BW), .GAP_CYC(GAP), .ORDER_MODE(0)) uut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .ext_first(ext_first),
      .std_val(std_val), .ext_val(ext_val), .banks_idle(banks_idle),
      .burst_busy(burst_busy), .dpd_enter(dpd_enter), .pwr_lost(pwr_lost),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .ready(ready));

   int    n_cmp = 0, n_bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // reference: queue of pending bus items (0 hold, 1 nop, 2 load std, 3 load ext)
   int            q[$];
   logic [AW-1:0] m_std = '0, m_ext = '0;
   logic          m_rdy = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         m_rdy = 1'b0;
      end else if (dpd_enter || pwr_lost) begin
         q.delete();
         m_rdy = 1'b0;
      end else if (q.size() == 0) begin
         if (start_req) begin
            m_rdy = 1'b0;
            m_std = std_val;
            m_ext = ext_val;
            q.push_back(0);
            q.push_back(ext_first ? 3 : 2);
            repeat (GAP) q.push_back(1);
            q.push_back(0);
            q.push_back(ext_first ? 2 : 3);
            repeat (GAP) q.push_back(1);
         end
      end else if (q[0] != 0 || (banks_idle && !burst_busy)) begin
         void'(q.pop_front());
         if (q.size() == 0) m_rdy = 1'b1;
      end
   end

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         int            it;
         logic [3:0]    e_cmd;
         logic [BW-1:0] e_ba;
         logic [AW-1:0] e_addr;
         it     = (q.size() != 0) ? q[0] : 0;
         e_cmd  = (it == 1) ? 4'b0111 : (it >= 2) ? 4'b0000 : 4'b1111;
         e_ba   = (it == 3) ? BW'(2) : '0;
         e_addr = (it == 2) ? m_std : (it == 3) ? m_ext : '0;
         check("cmd", 32'({cs_n, ras_n, cas_n, we_n}), 32'(e_cmd));
         check("ba", 32'(ba), 32'(e_ba));
         check("addr", 32'(addr), 32'(e_addr));
         check("ready", 32'(ready), 32'(m_rdy));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic pulse_start(input logic order);
      ext_first = order;
      start_req = 1'b1;
      cyc(1);
      start_req = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL %s watchdog: actual=timeout expected=completion", cur_req);
      finish_run();
   end

   initial begin
      cur_req = "R1 reset";
      cyc(3);
      rst_n = 1'b1;
      cyc(3);

      cur_req = "R2/R3 standard first";
      std_val = 13'h0032; ext_val = 13'h0041;
      pulse_start(1'b0);
      cyc(2 * GAP + 6);

      cur_req = "R6 ready hold";
      cyc(8);

      cur_req = "R10 restart with ext first R4";
      std_val = 13'h1AB5; ext_val = 13'h0C3E;
      pulse_start(1'b1);
      cyc(2 * GAP + 6);

      cur_req = "R5 hold-off first load";
      banks_idle = 1'b0;
      pulse_start(1'b0);
      cyc(4);
      burst_busy = 1'b1;
      banks_idle = 1'b1;
      cyc(3);
      burst_busy = 1'b0;
      cyc(2);
      banks_idle = 1'b0;
      cyc(GAP + 1);
      cur_req = "R5 hold-off second load";
      cyc(4);
      banks_idle = 1'b1;
      burst_busy = 1'b1;
      cyc(3);
      burst_busy = 1'b0;
      cyc(GAP + 4);

      cur_req = "R7 start while running, R9 value capture";
      std_val = 13'h0777; ext_val = 13'h1111;
      pulse_start(1'b0);
      std_val = 13'h1FFF; ext_val = 13'h0000;
      cyc(1);
      start_req = 1'b1; ext_first = 1'b1;
      cyc(1);
      start_req = 1'b0;
      cyc(GAP);
      start_req = 1'b1;
      cyc(1);
      start_req = 1'b0;
      cyc(GAP + 6);

      cur_req = "R8 deep power-down while ready";
      dpd_enter = 1'b1;
      cyc(1);
      dpd_enter = 1'b0;
      cyc(3);

      cur_req = "R8 power loss mid sequence";
      std_val = 13'h0123; ext_val = 13'h0456;
      pulse_start(1'b0);
      cyc(3);
      pwr_lost = 1'b1;
      cyc(2);
      pwr_lost = 1'b0;
      cyc(3);

      cur_req = "R8 power-down beats start";
      dpd_enter = 1'b1; start_req = 1'b1;
      cyc(1);
      dpd_enter = 1'b0; start_req = 1'b0;
      cyc(3);

      cur_req = "R2/R4 full run after abort";
      pulse_start(1'b1);
      cyc(2 * GAP + 8);

      finish_run();
   end
endmodule